// File: doc/BRIEF.md
# Dual-Strobe Synchronous Burst SRAM

This block is a synchronous static RAM meant to sit behind a processor as a secondary cache data store. Each word is split into byte lanes, and each lane carries one extra parity bit. Two active-low address strobes can start an access. One strobe belongs to the processor and the other to the cache controller. Once a base address is loaded, an internal two-bit beat counter walks through a four-word block in interleaved order. A burst-advance input moves the counter forward. Holding that input high inserts wait states.

The processor strobe always wins and always reads. The controller strobe reads or writes according to the lane write enables. A processor-started write therefore uses two cycles: a load with the processor strobe, then a cycle with both strobes high and the lane enables asserted. Chip enable is looked at only when a base address loads. That captured value then governs the whole burst. Read data is registered. The data bus is tri-stated through an output enable, and the drive state is also given as a separate flag.

Top module: `burst_sram`

## Requirements
- R1: Reset has these effects:
  - The output-drive flag `dout_en` is 0.
  - The captured chip enable is cleared.
  - Cycles with both strobes high read nothing until a base address has been loaded with chip enable low.
- R2: When `ads_cpu_n` is 0 at a rising edge, the following happens:
  - `addr` is loaded as the new base.
  - A read is performed, whatever `we_n` and `ads_ctl_n` are.
  - The word appears on `dout` after that edge.
- R3: When `ads_ctl_n` is 0 and `ads_cpu_n` is 1 at a rising edge, `addr` is loaded as the new base. The cycle writes if any bit of `we_n` is 0, and reads otherwise.
- R4: On the cycle after a processor-strobe load, the following inputs write `din` into the loaded word:
  - both strobes at 1;
  - `adv_n` at 1;
  - a `we_n` bit at 0.
- R5: `ce_n` is sampled only on a load cycle. If it was 1 there, then until the next load no word is written or read and `dout_en` stays 0, whatever `ce_n` does meanwhile.
- R6: On a non-load cycle with `adv_n` = 0, the beat counter steps before the access. The two low address bits are the loaded low bits XOR the counter (1, 2, 3, then back to 0). The upper address bits never change within a burst.
- R7: On a non-load cycle with `adv_n` = 1, the access repeats at the current address (wait state).
- R8: `we_n[0]` enables lane 0 (bits 8:0) and `we_n[1]` enables lane 1 (bits 17:9). A write changes only the enabled lanes of the word.
- R9: `dout_en` is 1 exactly when two conditions hold:
  - the last edge performed a read with chip enable active;
  - `oe_n` is 0 at that moment, with `oe_n` acting without a clock.
  While `dout_en` is 0, `dout` is high impedance.
- R10: After a write edge `dout_en` is 0, and the read register is not reloaded by the write.
- R11: A load during a burst abandons it, and the new burst restarts its counter at the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state captures on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | External word address |
| ads_cpu_n | input | 1 | Processor address strobe, active low, highest priority |
| ads_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Chip enable, active low, sampled on loads |
| we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data, high impedance when not driven |
| dout_en | output | 1 | High while `dout` is driven |

## Verification
Two collisions can happen in one cycle.

The first is both strobes low together with asserted lane enables and junk on `din`. The bench provokes this and judges it by the unchanged stored word on a later read, while the same cycle returns read data. That shows the processor strobe won and its read semantics took hold.

The second is a new load arriving mid-burst while `adv_n` is low. It is judged by the next beats: they must follow the new base from counter zero, not the old sequence.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  // Interleaved beat order: low bits of the beat are base bits XOR count.
  function automatic logic [1:0] beat_low(input logic [1:0] base_low,
                                          input logic [1:0] count);
    return base_low ^ count;
  endfunction

  // Next beat count: a load restarts, an advance steps, otherwise hold.
  function automatic logic [1:0] next_count(input logic load,
                                            input logic advance,
                                            input logic [1:0] count);
    if (load)         return 2'd0;
    else if (advance) return count + 2'd1;
    else              return count;
  endfunction

endpackage

// File: rtl/bsr_seq.sv
module bsr_seq
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ads_cpu_n,
  input  logic              ads_ctl_n,
  input  logic              adv_n,
  input  logic              ce_n,
  input  logic [LANES-1:0]  we_n,
  output logic [ADDR_W-1:0] acc_addr,
  output acc_kind_e         acc_kind,
  output logic              load_any
);

  logic              load_cpu;
  logic              load_ctl;
  logic              ce_live;
  logic              wr_req;
  logic [1:0]        cnt_q;
  logic [1:0]        cnt_nxt;
  logic              ce_q;
  logic [ADDR_W-1:0] base_q;

  assign load_cpu = ~ads_cpu_n;
  assign load_ctl = ads_cpu_n & ~ads_ctl_n;
  assign load_any = load_cpu | load_ctl;
  assign wr_req   = |(~we_n);
  assign cnt_nxt  = next_count(load_any, ~adv_n, cnt_q);
  assign ce_live  = load_any ? ~ce_n : ce_q;

  always_comb begin
    if (load_any) acc_addr = addr;
    else          acc_addr = {base_q[ADDR_W-1:2], beat_low(base_q[1:0], cnt_nxt)};
  end

  always_comb begin
    if (!ce_live)      acc_kind = ACC_IDLE;
    else if (load_cpu) acc_kind = ACC_READ;
    else if (wr_req)   acc_kind = ACC_WRITE;
    else               acc_kind = ACC_READ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
      ce_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (load_any) begin
        base_q <= addr;
        ce_q   <= ~ce_n;
      end
    end
  end

endmodule

// File: rtl/bsr_array.sv
module bsr_array
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       acc_addr,
  input  acc_kind_e               acc_kind,
  input  logic [LANES-1:0]        we_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_drive
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (acc_kind == ACC_WRITE && !we_n[g])
        mem[acc_addr] <= din[g*LANE_W +: LANE_W];
      if (acc_kind == ACC_READ)
        rd_q <= mem[acc_addr];
    end

    assign rd_data[g*LANE_W +: LANE_W] = rd_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_drive <= 1'b0;
    else        rd_drive <= (acc_kind == ACC_READ);
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ads_cpu_n,
  input  logic              ads_ctl_n,
  input  logic              adv_n,
  input  logic              ce_n,
  input  logic [LANES-1:0]  we_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  logic [ADDR_W-1:0] acc_addr;
  acc_kind_e         acc_kind;
  logic              load_any;
  logic [DATA_W-1:0] rd_data;
  logic              rd_drive;

  bsr_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n), .adv_n(adv_n),
    .ce_n(ce_n), .we_n(we_n),
    .acc_addr(acc_addr), .acc_kind(acc_kind), .load_any(load_any)
  );

  bsr_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_kind(acc_kind),
    .we_n(we_n), .din(din), .rd_data(rd_data), .rd_drive(rd_drive)
  );

  assign dout_en = rd_drive & ~oe_n;
  assign dout    = dout_en ? rd_data : {DATA_W{1'bz}};

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ads_cpu_n,
  input logic              ads_ctl_n,
  input logic              adv_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic [LANES-1:0]  we_n,
  input logic              dout_en,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              load_any
);

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_oe_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  p_cpu_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_cpu_n && !ce_n) |=> (dout_en || oe_n));

  p_ctl_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ads_cpu_n && !ads_ctl_n && !ce_n && (we_n != '1)) |=> !dout_en);

  p_ce_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_any && ce_n) |=> !dout_en);

  p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !load_any && adv_n) |-> (acc_addr == $past(acc_addr)));

  p_adv_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !load_any && !adv_n) |->
      ((acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2])) &&
       (acc_addr[1:0] != $past(acc_addr[1:0]))));

endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n),
  .adv_n(adv_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .dout_en(dout_en), .acc_addr(acc_addr), .load_any(load_any)
);

// File: tb/burst_sram_test.sv
module burst_sram_test;

  localparam int PERIOD = 10;
  localparam int NV     = 24;

  typedef struct packed {
    logic        c;
    logic        k;
    logic        v;
    logic [1:0]  we;
    logic        ce;
    logic [7:0]  a;
    logic [17:0] d;
    logic        en;
    logic [17:0] q;
  } vec_t;

  // Fields: cpu strobe, ctl strobe, advance, we_n, ce_n, addr, din, exp drive, exp data
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b1,2'b00,1'b0,8'h10,18'h10010,1'b0,18'h0},     // 0 R3 ctl write, R10
    '{1'b1,1'b0,1'b1,2'b00,1'b0,8'h11,18'h11111,1'b0,18'h0},     // 1 R3
    '{1'b1,1'b0,1'b1,2'b00,1'b0,8'h12,18'h12222,1'b0,18'h0},     // 2 R3
    '{1'b1,1'b0,1'b1,2'b00,1'b0,8'h13,18'h13333,1'b0,18'h0},     // 3 R3
    '{1'b0,1'b1,1'b1,2'b11,1'b0,8'h11,18'h0,1'b1,18'h11111},     // 4 R2 cpu read
    '{1'b1,1'b1,1'b0,2'b11,1'b0,8'h00,18'h0,1'b1,18'h10010},     // 5 R6 beat 1
    '{1'b1,1'b1,1'b0,2'b11,1'b0,8'h00,18'h0,1'b1,18'h13333},     // 6 R6 beat 2
    '{1'b1,1'b1,1'b1,2'b11,1'b0,8'h00,18'h0,1'b1,18'h13333},     // 7 R7 wait
    '{1'b1,1'b1,1'b0,2'b11,1'b0,8'h00,18'h0,1'b1,18'h12222},     // 8 R6 beat 3
    '{1'b1,1'b1,1'b0,2'b11,1'b0,8'h00,18'h0,1'b1,18'h11111},     // 9 R6 wrap
    '{1'b0,1'b0,1'b1,2'b00,1'b0,8'h12,18'h3FFFF,1'b1,18'h12222}, // 10 R2 priority
    '{1'b1,1'b1,1'b1,2'b10,1'b0,8'h00,18'h3FEAA,1'b0,18'h0},     // 11 R4 R8 lane0
    '{1'b1,1'b1,1'b1,2'b11,1'b0,8'h00,18'h0,1'b1,18'h122AA},     // 12 R4 R8 R7
    '{1'b1,1'b0,1'b1,2'b11,1'b0,8'h12,18'h0,1'b1,18'h122AA},     // 13 R3 ctl read
    '{1'b1,1'b0,1'b1,2'b11,1'b1,8'h10,18'h0,1'b0,18'h0},         // 14 R5 ce off
    '{1'b1,1'b1,1'b0,2'b11,1'b0,8'h00,18'h0,1'b0,18'h0},         // 15 R5 ce ignored
    '{1'b1,1'b1,1'b1,2'b00,1'b0,8'h00,18'h0,1'b0,18'h0},         // 16 R5 write dropped
    '{1'b0,1'b1,1'b1,2'b11,1'b0,8'h11,18'h0,1'b1,18'h11111},     // 17 R5 word kept
    '{1'b1,1'b0,1'b1,2'b01,1'b0,8'h11,18'h0,1'b0,18'h0},         // 18 R8 lane1
    '{1'b0,1'b1,1'b1,2'b11,1'b0,8'h11,18'h0,1'b1,18'h00111},     // 19 R8
    '{1'b0,1'b1,1'b1,2'b11,1'b0,8'h12,18'h0,1'b1,18'h122AA},     // 20 R11
    '{1'b1,1'b1,1'b0,2'b11,1'b0,8'h00,18'h0,1'b1,18'h13333},     // 21 R11
    '{1'b0,1'b1,1'b0,2'b11,1'b0,8'h10,18'h0,1'b1,18'h10010},     // 22 R11 abandon
    '{1'b1,1'b1,1'b0,2'b11,1'b0,8'h00,18'h0,1'b1,18'h00111}      // 23 R11 restart
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        ads_cpu_n, ads_ctl_n, adv_n, ce_n, oe_n;
  logic [1:0]  we_n;
  logic [17:0] din;
  logic [17:0] dout;
  logic        dout_en;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  burst_sram uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ads_cpu_n(ads_cpu_n),
    .ads_ctl_n(ads_ctl_n), .adv_n(adv_n), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, k, v, input logic [1:0] we, input logic ce,
                       input logic [7:0] a, input logic [17:0] d);
    @(negedge clk);
    ads_cpu_n = c; ads_ctl_n = k; adv_n = v; we_n = we; ce_n = ce; addr = a; din = d;
    @(posedge clk);
    #(PERIOD/4);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ads_cpu_n = 1'b1; ads_ctl_n = 1'b1; adv_n = 1'b1;
    we_n = 2'b11; ce_n = 1'b0; oe_n = 1'b0; addr = '0; din = '0;
    repeat (3) @(posedge clk);
    #(PERIOD/4);
    chk("R1 reset drive", {17'd0, dout_en}, 18'd0);
    @(negedge clk) rst_n = 1'b1;
    drive(1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 8'h00, 18'h0);
    chk("R1 idle before load", {17'd0, dout_en}, 18'd0);
    drive(1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 8'h00, 18'h0);
    chk("R1 advance before load", {17'd0, dout_en}, 18'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].c, VECS[i].k, VECS[i].v, VECS[i].we, VECS[i].ce, VECS[i].a, VECS[i].d);
      chk($sformatf("table[%0d] drive", i), {17'd0, dout_en}, {17'd0, VECS[i].en});
      if (VECS[i].en)
        chk($sformatf("table[%0d] data", i), dout, VECS[i].q);
    end

    // R9: output enable gates the bus without a clock edge
    drive(1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 8'h00, 18'h0);
    chk("R9 hold read data", dout, 18'h00111);
    oe_n = 1'b1; #1;
    chk("R9 oe off", {17'd0, dout_en}, 18'd0);
    oe_n = 1'b0; #1;
    chk("R9 oe back on", {17'd0, dout_en}, 18'd1);

    // R6: upper address bits stay fixed while advancing
    drive(1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 8'h23, 18'h2BEEF);
    drive(1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 8'h22, 18'h0);
    drive(1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 8'h00, 18'h0);
    chk("R6 advance to 0x23", dout, 18'h2BEEF);

    // R10: write after read leaves bus undriven, read register unchanged after
    drive(1'b1, 1'b1, 1'b1, 2'b01, 1'b0, 8'h00, 18'h00000);
    chk("R10 write cycle undriven", {17'd0, dout_en}, 18'd0);
    drive(1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 8'h00, 18'h0);
    chk("R10 later read merged", dout, 18'h000EF);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule